// File: doc/BRIEF.md
# Multiplexed Asynchronous Memory Interface Controller

This block turns single read or write requests from an on-chip host into accesses on an external asynchronous NOR flash or pseudo-static RAM device. The device shares one 16-bit bus between the low address bits and the data, and takes the upper address bits on a separate bus. Each access runs three phases whose lengths are counted in system clocks: an address phase with the address-valid strobe low, an address-hold phase that keeps the address on the shared bus with the strobe released, and a data phase with the read or write strobe low. A write adds one more clock in which the data is still driven and the write strobe is high.

The host raises a request with direction, a 26-bit address and write data, and holds it until a one-cycle acknowledge returns together with read data and an error flag. Configuration inputs give the multiplex enable, the memory type, a write permission bit and the three 4-bit timing fields. They are sampled when a request is accepted. Requests that the configuration does not allow are acknowledged with the error flag set, and no external strobe moves.

Top module: `mux_mem_ctrl`

## Requirements
- R1: During an access, `mem_addr_hi` carries address bits 25:16 and stays stable. In every address-phase and address-hold clock, `mem_ad_oe` is 1 and `mem_ad_out` equals address bits 15:0.
- R2: The address phase lasts max(`cfg_aset`,1) clocks with `mem_adv_n` low, `mem_ce_n` low and both `mem_oe_n` and `mem_we_n` high.
- R3: The address-hold phase lasts `cfg_ahld` clocks, with zero skipping it. In it `mem_adv_n`, `mem_oe_n` and `mem_we_n` are high and `mem_ce_n` is low.
- R4: The data phase lasts max(`cfg_dset`,1) clocks. `mem_oe_n` is low on reads and `mem_we_n` is low on writes, and the two are never low together.
- R5: On a write, `mem_ad_out` equals the write data with `mem_ad_oe` 1 throughout the data phase and for exactly one further clock, in which `mem_we_n` is high and `mem_ce_n` low.
- R6: On a read, `mem_ad_oe` is 0 whenever `mem_oe_n` is low. The read data is the value on `mem_ad_in` in the last data-phase clock.
- R7: `mem_ce_n` is low from the first address-phase clock to the end of the access, and high in the acknowledge cycle, so there is at least one idle clock between accesses.
- R8: `req_ack` is a one-cycle pulse per request. It follows the final access clock, and on reads it comes with `req_rdata` valid.
- R9: A write request while `cfg_wr_en` is 0 is acknowledged with `req_err` 1 in the cycle after acceptance, and no external strobe is asserted. Reads still run normally.
- R10: If `cfg_mux_en` is 0, or `cfg_mem_type` is neither 2'b01 (pseudo-static RAM) nor 2'b10 (NOR flash), every request is acknowledged with `req_err` 1 and no external activity. 2'b00 (plain static RAM) and 2'b11 are rejected.
- R11: After reset all strobes are high, `mem_ad_oe` is 0 and `req_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mux_en | input | 1 | Address/data multiplex enable |
| cfg_mem_type | input | 2 | Memory type: 01 pseudo-static RAM, 10 NOR flash |
| cfg_wr_en | input | 1 | Write permission |
| cfg_aset | input | 4 | Address phase length in clocks (0 acts as 1) |
| cfg_ahld | input | 4 | Address-hold phase length in clocks |
| cfg_dset | input | 4 | Data phase length in clocks (0 acts as 1) |
| req_valid | input | 1 | Host request, held until acknowledge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 26 | Access address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request refused, valid with acknowledge |
| req_rdata | output | 16 | Read data |
| mem_addr_hi | output | 10 | Upper address bits to the device |
| mem_ad_out | output | 16 | Shared bus value driven by the block |
| mem_ad_oe | output | 1 | Shared bus drive enable |
| mem_ad_in | input | 16 | Shared bus value driven by the device |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
Reads and writes run under several timing sets: all minimum, zero fields that must clamp to one clock, zero hold that must skip the phase, mixed mid values and all maximum. Counting each phase separately shows whether a phase is miscounted, merged or dropped. The device model returns a value that steps on every data-phase clock, so a capture on any clock but the last one shows up. Refused requests come from each configuration cause in turn: write permission off, multiplexing off, and each unsupported memory type. Reads with write permission off show that only writes are blocked.

// File: rtl/mmc_pkg.sv
package mmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ASET  = 3'd1,
    ST_AHLD  = 3'd2,
    ST_DSET  = 3'd3,
    ST_WTAIL = 3'd4,
    ST_ACK   = 3'd5
  } mmc_state_e;

  localparam logic [1:0] MT_SRAM  = 2'b00;
  localparam logic [1:0] MT_PSRAM = 2'b01;
  localparam logic [1:0] MT_NOR   = 2'b10;

  // Phase length of at least one clock
  function automatic logic [3:0] min_one(input logic [3:0] v);
    return (v == 4'd0) ? 4'd1 : v;
  endfunction

endpackage

// File: rtl/mmc_phase_timer.sv
module mmc_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/mmc_seq.sv
module mmc_seq
  import mmc_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          cfg_mux_en,
  input  logic [1:0]    cfg_mem_type,
  input  logic          cfg_wr_en,
  input  logic [TW-1:0] cfg_aset,
  input  logic [TW-1:0] cfg_ahld,
  input  logic [TW-1:0] cfg_dset,
  input  logic          tmr_last,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          accept,
  output mmc_state_e    state,
  output logic          is_write,
  output logic          err_flag
);
  mmc_state_e    st_q, st_d;
  logic          wr_q, wr_d;
  logic          err_q, err_d;
  logic [TW-1:0] hld_q, hld_d;
  logic [TW-1:0] dat_q, dat_d;
  logic          type_ok, blocked;

  assign type_ok = (cfg_mem_type == MT_PSRAM) || (cfg_mem_type == MT_NOR);
  assign blocked = !cfg_mux_en || !type_ok || (req_write && !cfg_wr_en);
  assign accept  = (st_q == ST_IDLE) && req_valid;

  always_comb begin
    st_d     = st_q;
    wr_d     = wr_q;
    err_d    = err_q;
    hld_d    = hld_q;
    dat_d    = dat_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          wr_d  = req_write;
          hld_d = cfg_ahld;
          dat_d = TW'(min_one(4'(cfg_dset)));
          if (blocked) begin
            err_d = 1'b1;
            st_d  = ST_ACK;
          end else begin
            err_d    = 1'b0;
            st_d     = ST_ASET;
            tmr_load = 1'b1;
            tmr_val  = TW'(min_one(4'(cfg_aset))) - 1'b1;
          end
        end
      end
      ST_ASET: begin
        if (tmr_last) begin
          tmr_load = 1'b1;
          if (hld_q != '0) begin
            st_d    = ST_AHLD;
            tmr_val = hld_q - 1'b1;
          end else begin
            st_d    = ST_DSET;
            tmr_val = dat_q - 1'b1;
          end
        end
      end
      ST_AHLD: begin
        if (tmr_last) begin
          st_d     = ST_DSET;
          tmr_load = 1'b1;
          tmr_val  = dat_q - 1'b1;
        end
      end
      ST_DSET: begin
        if (tmr_last) st_d = wr_q ? ST_WTAIL : ST_ACK;
      end
      ST_WTAIL: st_d = ST_ACK;
      ST_ACK:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      wr_q  <= 1'b0;
      err_q <= 1'b0;
      hld_q <= '0;
      dat_q <= '0;
    end else begin
      st_q  <= st_d;
      wr_q  <= wr_d;
      err_q <= err_d;
      hld_q <= hld_d;
      dat_q <= dat_d;
    end
  end

  assign state    = st_q;
  assign is_write = wr_q;
  assign err_flag = err_q;
endmodule

// File: rtl/mmc_bus_drv.sv
module mmc_bus_drv
  import mmc_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  mmc_state_e    state,
  input  logic          is_write,
  input  logic          tmr_last,
  input  logic [DW-1:0] mem_ad_in,
  output logic [HW-1:0] mem_addr_hi,
  output logic [DW-1:0] mem_ad_out,
  output logic          mem_ad_oe,
  output logic          mem_adv_n,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic [DW-1:0] rdat_q, rdat_d;
  logic          cap_en;
  logic          addr_ph, in_acc;

  // Request fields latched on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  // Read capture on the final data clock
  assign cap_en = (state == ST_DSET) && tmr_last && !is_write;
  assign rdat_d = cap_en ? mem_ad_in : rdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdat_q <= '0;
    else        rdat_q <= rdat_d;
  end

  assign addr_ph = (state == ST_ASET) || (state == ST_AHLD);
  assign in_acc  = addr_ph || (state == ST_DSET) || (state == ST_WTAIL);

  always_comb begin
    mem_ad_oe  = 1'b0;
    mem_ad_out = '0;
    if (addr_ph) begin
      mem_ad_oe  = 1'b1;
      mem_ad_out = addr_q[DW-1:0];
    end else if (is_write && ((state == ST_DSET) || (state == ST_WTAIL))) begin
      mem_ad_oe  = 1'b1;
      mem_ad_out = wdat_q;
    end
  end

  assign mem_addr_hi = addr_q[AW-1:DW];
  assign mem_ce_n    = !in_acc;
  assign mem_adv_n   = !(state == ST_ASET);
  assign mem_oe_n    = !((state == ST_DSET) && !is_write);
  assign mem_we_n    = !((state == ST_DSET) && is_write);
  assign rdata       = rdat_q;
endmodule

// File: rtl/mux_mem_ctrl.sv
module mux_mem_ctrl
  import mmc_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 16,
  parameter int TW = 4,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mux_en,
  input  logic [1:0]    cfg_mem_type,
  input  logic          cfg_wr_en,
  input  logic [TW-1:0] cfg_aset,
  input  logic [TW-1:0] cfg_ahld,
  input  logic [TW-1:0] cfg_dset,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic          req_err,
  output logic [DW-1:0] req_rdata,
  output logic [HW-1:0] mem_addr_hi,
  output logic [DW-1:0] mem_ad_out,
  output logic          mem_ad_oe,
  input  logic [DW-1:0] mem_ad_in,
  output logic          mem_adv_n,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);
  logic          tmr_load, tmr_last, accept, is_write, err_flag;
  logic [TW-1:0] tmr_val;
  mmc_state_e    state;

  mmc_phase_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  mmc_seq #(.TW(TW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .cfg_mux_en   (cfg_mux_en),
    .cfg_mem_type (cfg_mem_type),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_aset     (cfg_aset),
    .cfg_ahld     (cfg_ahld),
    .cfg_dset     (cfg_dset),
    .tmr_last     (tmr_last),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .accept       (accept),
    .state        (state),
    .is_write     (is_write),
    .err_flag     (err_flag)
  );

  mmc_bus_drv #(.AW(AW), .DW(DW)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .state       (state),
    .is_write    (is_write),
    .tmr_last    (tmr_last),
    .mem_ad_in   (mem_ad_in),
    .mem_addr_hi (mem_addr_hi),
    .mem_ad_out  (mem_ad_out),
    .mem_ad_oe   (mem_ad_oe),
    .mem_adv_n   (mem_adv_n),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .rdata       (req_rdata)
  );

  assign req_ack = (state == ST_ACK);
  assign req_err = req_ack && err_flag;
endmodule

// File: rtl/mmc_checker.sv
module mmc_checker #(
  parameter int HW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ack,
  input logic          req_err,
  input logic [HW-1:0] mem_addr_hi,
  input logic          mem_ad_oe,
  input logic          mem_adv_n,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n
);
  AST_ADV_WITHIN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_ce_n && mem_oe_n && mem_we_n); // R2
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R4
  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ad_oe); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack); // R8
  AST_CE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> mem_ce_n); // R7
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr_hi)); // R1
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && req_err) |-> $past(mem_ce_n)); // R9
  AST_DATA_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_ce_n); // R4
endmodule

bind mux_mem_ctrl mmc_checker #(.HW(HW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ack     (req_ack),
  .req_err     (req_err),
  .mem_addr_hi (mem_addr_hi),
  .mem_ad_oe   (mem_ad_oe),
  .mem_adv_n   (mem_adv_n),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n)
);

// File: tb/tb_mux_mem_ctrl.sv
module tb_mux_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mux_en = 1'b1;
  logic [1:0]  cfg_mem_type = 2'b01;
  logic        cfg_wr_en = 1'b1;
  logic [3:0]  cfg_aset = 4'd1, cfg_ahld = 4'd0, cfg_dset = 4'd1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack, req_err;
  logic [15:0] req_rdata;
  logic [9:0]  mem_addr_hi;
  logic [15:0] mem_ad_out, mem_ad_in;
  logic        mem_ad_oe, mem_adv_n, mem_ce_n, mem_oe_n, mem_we_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mux_mem_ctrl dut (.*);

  // Device model: latches the address on the strobe, read value steps per data clock
  logic [15:0] lat_lo;
  logic [3:0]  oe_cnt;
  always @(posedge clk) begin
    if (!mem_adv_n) lat_lo <= mem_ad_out;
    if (!mem_oe_n) oe_cnt <= oe_cnt + 4'd1;
    else           oe_cnt <= 4'd0;
  end
  assign mem_ad_in = !mem_oe_n ? ((lat_lo ^ 16'h5A3C) + 16'(oe_cnt)) : 16'hDEAD;

  typedef struct {
    bit          wr;
    logic [25:0] addr;
    logic [15:0] wdata;
    int          a, h, d;
    bit          err;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int clamp1(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic access(input bit wr, input logic [25:0] addr, input logic [15:0] wd);
    exp_t e;
    bit blk;
    blk = !cfg_mux_en || !(cfg_mem_type == 2'b01 || cfg_mem_type == 2'b10) || (wr && !cfg_wr_en);
    e.wr = wr; e.addr = addr; e.wdata = wd; e.err = blk;
    e.a = blk ? 0 : clamp1(cfg_aset);
    e.h = blk ? 0 : int'(cfg_ahld);
    e.d = blk ? 0 : clamp1(cfg_dset);
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  int n_as = 0, n_ah = 0, n_d = 0, n_tail = 0;
  bit bus_ok = 1'b1, hi_ok = 1'b1, prev_ack = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ack)
        chk(!req_ack, "R8 ack width", req_ack, 0);
      prev_ack = req_ack;
      if (!mem_ce_n && exp_q.size() > 0) begin
        if (mem_addr_hi != exp_q[0].addr[25:16]) hi_ok = 1'b0;
        if (!mem_adv_n) begin
          n_as++;
          if (!mem_ad_oe || mem_ad_out != exp_q[0].addr[15:0] || !mem_oe_n || !mem_we_n) bus_ok = 1'b0;
        end else if (!mem_oe_n) begin
          n_d++;
          if (mem_ad_oe || exp_q[0].wr) bus_ok = 1'b0;
        end else if (!mem_we_n) begin
          n_d++;
          if (!mem_ad_oe || mem_ad_out != exp_q[0].wdata || !exp_q[0].wr) bus_ok = 1'b0;
        end else if (n_d == 0) begin
          n_ah++;
          if (!mem_ad_oe || mem_ad_out != exp_q[0].addr[15:0]) bus_ok = 1'b0;
        end else begin
          n_tail++;
          if (!mem_ad_oe || mem_ad_out != exp_q[0].wdata) bus_ok = 1'b0;
        end
      end
      if (req_ack) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected ack", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(mem_ce_n, "R7 ce high in ack cycle", mem_ce_n, 1);
          chk(req_err == e.err, e.wr ? "R9 error flag" : "R10 error flag", req_err, e.err);
          chk(n_as == e.a, "R2 address phase clocks", n_as, e.a);
          chk(n_ah == e.h, "R3 hold phase clocks", n_ah, e.h);
          chk(n_d == e.d, "R4 data phase clocks", n_d, e.d);
          chk(n_tail == ((e.wr && !e.err) ? 1 : 0), "R5 write tail clocks", n_tail, (e.wr && !e.err) ? 1 : 0);
          chk(bus_ok, "R1 R5 R6 shared bus content", bus_ok, 1);
          chk(hi_ok, "R1 upper address", mem_addr_hi, e.addr[25:16]);
          if (!e.wr && !e.err)
            chk(req_rdata == (e.addr[15:0] ^ 16'h5A3C) + 16'(e.d - 1), "R6 R8 read data last clock",
                req_rdata, (e.addr[15:0] ^ 16'h5A3C) + 16'(e.d - 1));
        end
        n_as = 0; n_ah = 0; n_d = 0; n_tail = 0; bus_ok = 1'b1; hi_ok = 1'b1;
      end
    end
  end

  task automatic timing(input logic [3:0] a, input logic [3:0] h, input logic [3:0] d);
    cfg_aset = a; cfg_ahld = h; cfg_dset = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n, "R11 strobes idle", {mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n}, 4'hF);
    chk(!mem_ad_oe, "R11 bus released", mem_ad_oe, 0);
    chk(!req_ack, "R11 no ack", req_ack, 0);
    rst_n = 1'b1;
    @(negedge clk);

    timing(4'd1, 4'd0, 4'd1);
    access(1'b0, 26'h2A_1234, 16'h0);
    access(1'b1, 26'h15_4321, 16'hBEEF);
    timing(4'd3, 4'd2, 4'd4);
    access(1'b0, 26'h3FF_FFFF, 16'h0);
    access(1'b1, 26'h000_0001, 16'h1357);
    timing(4'd0, 4'd1, 4'd0);
    access(1'b0, 26'h0AB_CDEF, 16'h0);
    access(1'b1, 26'h123_4567, 16'hA5A5);
    timing(4'd15, 4'd15, 4'd15);
    cfg_mem_type = 2'b10;
    access(1'b0, 26'h200_8001, 16'h0);
    access(1'b1, 26'h1C0_0FF0, 16'h0F0F);
    timing(4'd2, 4'd0, 4'd3);
    access(1'b1, 26'h055_AA55, 16'hFFFF);
    access(1'b0, 26'h055_AA55, 16'h0);
    // R9 write blocked, read allowed
    cfg_wr_en = 1'b0;
    access(1'b1, 26'h111_2222, 16'h3333);
    access(1'b0, 26'h111_2222, 16'h0);
    cfg_wr_en = 1'b1;
    // R10 refused configurations
    cfg_mux_en = 1'b0;
    access(1'b0, 26'h001_0002, 16'h0);
    access(1'b1, 26'h001_0002, 16'h4444);
    cfg_mux_en = 1'b1;
    cfg_mem_type = 2'b00;
    access(1'b0, 26'h002_0003, 16'h0);
    cfg_mem_type = 2'b11;
    access(1'b1, 26'h003_0004, 16'h5555);
    cfg_mem_type = 2'b01;
    access(1'b0, 26'h004_0005, 16'h0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all requests acknowledged", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule